// File: doc/BRIEF.md
# Access-Sequence Memory Guard

This block watches the address stream of a processor bus in front of a flash and RAM space, and keeps the read-protection state of a flash region. There is no control register. Protection is turned on or off by the pattern of accesses the processor makes:

- A run of accesses to small "unlock" address windows is followed by an access to a "guard" window.
- A read of the guard window at the end of the run turns protection on; a write turns it off.
- Any access that falls outside every decoded window breaks the run.

While protection is on, reads of two secure windows are answered with filler data in place of memory contents.

The block also carries other address-decoded behaviour:

- Three address windows act as set/clear strobes for a 3-bit archive-limit value.
- Writes to the boot window are blocked from reaching memory.
- On the first hardware generation, repeated guard-window hits that never unlock count toward a sticky halt request.
- An execution-limit byte is loaded at reset; its value depends on the generation.

The block is purely an observer of bus addresses. Decode is combinational. It is qualified by a one-cycle `bus_valid` strobe. All state updates on the clock edge that ends the access.

Top module: `bus_seq_guard`

## Requirements
- R1: During and after reset, `protect`, `halt` and `arch_limit` are 0 and all internal counters are 0.
- R2: An access to an unlock window increments counter A when `gen2`=0, or counter B when `gen2`=1. The unlock windows are offsets 0x000000–0x00FFFF, 0x012000–0x017FFF and 0x01A000–0x01FFFF from `ROM_BASE`. A word access always counts. A byte access counts only when address bit 0 is 0.
- R3: An access to 0x1C0000–0x1FFFFF first adds 1 (byte) or 2 (word) to counter B. If A ≥ 3 or the new B ≥ 7, then on the next cycle `protect` is 1 after a read or 0 after a write, and A and B are zeroed.
- R4: On `gen2`=0, a guard-window access that misses the threshold of R3 adds 1 to a crash count (word, or byte at an even address). When that count reaches 4, `halt` is 1 from the next cycle, and A, B and the crash count are zeroed. `halt` is cleared only by reset and is never raised when `gen2`=1.
- R5: A valid access outside all decoded windows zeroes A, B and the crash count. The decoded windows are the archive windows, 0x180000–0x1BFFFF (no effect), the guard window, the unlock windows and the secure windows.
- R6: A read of offset 0x010000–0x011FFF or 0x018000–0x019FFF from `ROM_BASE` while `protect`=1 raises `sub_en` in the same cycle, with `sub_data`=0x1414 (0x14 in each byte lane). Writes there, and reads while `protect`=0, leave `sub_en` at 0.
- R7: The archive windows 0x040000–0x07FFFF, 0x080000–0x0BFFFF and 0x0C0000–0x0FFFFF select `arch_limit` bit 0, 1 and 2. A write sets the bit and a read clears it, visible on the next cycle. This happens only when `gen2`=0 and `protect`=0; otherwise the bit is unchanged.
- R8: `write_block` is 1 in the same cycle for a valid write to offset 0x000000–0x00FFFF from `ROM_BASE`, and 0 for every other access.
- R9: Counters A, B and crash saturate at 2^`CNT_W`−1 instead of wrapping.
- R10: `exec_limit` is loaded during reset with 0x18 when `gen2`=1 and with 0x00 when `gen2`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | One-cycle strobe marking a bus access |
| bus_addr | input | ADDR_W | Access address |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_word | input | 1 | 1 = 16-bit access, 0 = byte access |
| gen2 | input | 1 | Hardware generation: 0 = first, 1 = later |
| protect | output | 1 | Read-protection state |
| sub_en | output | 1 | Replace read data with `sub_data` |
| sub_data | output | 16 | Filler read value |
| write_block | output | 1 | Suppress this write to memory |
| arch_limit | output | 3 | Archive-limit value |
| halt | output | 1 | Sticky processor halt request |
| exec_limit | output | 8 | Flash execution-limit byte |

## Verification
The bench builds the block with `ADDR_W`=24, `ROM_BASE`=0x200000 and `CNT_W`=3. At that width the saturation limit 7 equals the counter B threshold, so a handful of accesses past saturation tells clipping apart from wrapping: a wrapped counter would fall below the unlock threshold. A sweep over every window edge, both directions and both access sizes checks the filler and write-blocking decode. Directed runs count unlock, guard and breaking accesses to exercise thresholds, halting and the archive strobes on both generations.

// File: rtl/bus_seq_guard.sv
module bus_seq_guard #(
  parameter int ADDR_W = 24,
  parameter int CNT_W = 4,
  parameter logic [ADDR_W-1:0] ROM_BASE = ADDR_W'(32'h200000),
  parameter logic [7:0] EXEC_INIT = 8'h18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_write,
  input  logic              bus_word,
  input  logic              gen2,
  output logic              protect,
  output logic              sub_en,
  output logic [15:0]       sub_data,
  output logic              write_block,
  output logic [2:0]        arch_limit,
  output logic              halt,
  output logic [7:0]        exec_limit
);

  localparam logic [CNT_W-1:0] CMAX = '1;
  localparam logic [CNT_W-1:0] A_TH = CNT_W'(3);
  localparam logic [CNT_W-1:0] B_TH = CNT_W'(7);
  localparam logic [CNT_W-1:0] C_TH = CNT_W'(4);

  function automatic logic inr(input logic [ADDR_W-1:0] v, input logic [31:0] lo, input logic [31:0] hi);
    return (v >= ADDR_W'(lo)) && (v <= ADDR_W'(hi));
  endfunction

  function automatic logic [CNT_W-1:0] sat_add(input logic [CNT_W-1:0] v, input logic [1:0] d);
    logic [CNT_W:0] s;
    s = {1'b0, v} + (CNT_W+1)'(d);
    return s[CNT_W] ? CMAX : s[CNT_W-1:0];
  endfunction

  logic [CNT_W-1:0] cnt_a, cnt_b, cnt_c;
  logic [ADDR_W-1:0] off;
  logic in_rom, in_arch, in_disp, in_guard, in_boot, in_auth, in_sec, counts;
  logic [CNT_W-1:0] b_pre, c_pre;
  logic hit;
  logic [1:0] arch_idx;

  assign off      = bus_addr - ROM_BASE;
  assign in_rom   = bus_addr >= ROM_BASE;
  assign in_arch  = inr(bus_addr, 32'h040000, 32'h0FFFFF);
  assign in_disp  = inr(bus_addr, 32'h180000, 32'h1BFFFF);
  assign in_guard = inr(bus_addr, 32'h1C0000, 32'h1FFFFF);
  assign in_boot  = in_rom && inr(off, 32'h000000, 32'h00FFFF);
  assign in_auth  = in_boot || (in_rom && (inr(off, 32'h012000, 32'h017FFF) || inr(off, 32'h01A000, 32'h01FFFF)));
  assign in_sec   = in_rom && (inr(off, 32'h010000, 32'h011FFF) || inr(off, 32'h018000, 32'h019FFF));
  assign counts   = bus_word || !bus_addr[0];
  assign arch_idx = bus_addr[19:18] - 2'd1;

  assign b_pre = sat_add(cnt_b, bus_word ? 2'd2 : 2'd1);
  assign c_pre = sat_add(cnt_c, {1'b0, counts});
  assign hit   = (cnt_a >= A_TH) || (b_pre >= B_TH);

  assign sub_en      = bus_valid && !bus_write && in_sec && protect;
  assign sub_data    = 16'h1414;
  assign write_block = bus_valid && bus_write && in_boot;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      protect    <= 1'b0;
      halt       <= 1'b0;
      arch_limit <= '0;
      cnt_a      <= '0;
      cnt_b      <= '0;
      cnt_c      <= '0;
      exec_limit <= gen2 ? EXEC_INIT : 8'h00;
    end else if (bus_valid) begin
      if (in_arch) begin
        if (!gen2 && !protect) arch_limit[arch_idx] <= bus_write;
      end else if (in_disp || in_sec) begin
      end else if (in_guard) begin
        if (hit) begin
          protect <= !bus_write;
          cnt_a   <= '0;
          cnt_b   <= '0;
        end else begin
          cnt_b <= b_pre;
          if (!gen2) begin
            if (c_pre >= C_TH) begin
              halt  <= 1'b1;
              cnt_a <= '0;
              cnt_b <= '0;
              cnt_c <= '0;
            end else begin
              cnt_c <= c_pre;
            end
          end
        end
      end else if (in_auth) begin
        if (counts) begin
          if (gen2) cnt_b <= sat_add(cnt_b, 2'd1);
          else      cnt_a <= sat_add(cnt_a, 2'd1);
        end
      end else begin
        cnt_a <= '0;
        cnt_b <= '0;
        cnt_c <= '0;
      end
    end
  end

  assert_halt_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> halt);
  assert_protect_moves_on_guard_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(protect) |-> $past(bus_valid && in_guard));
  assert_arch_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(arch_limit) |-> $past(bus_valid && !gen2 && !protect && in_arch));
  assert_block_write_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
    write_block |-> (bus_write && !sub_en));
  assert_sub_needs_protect_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sub_en |-> (protect && !bus_write));
  assert_no_halt_gen2_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (gen2 && !halt) |=> (!halt || !$past(gen2)));

endmodule

// File: tb/bus_seq_guard_tb.sv
module bus_seq_guard_tb;
  logic clk = 0, rst_n = 0, bus_valid = 0, bus_write = 0, bus_word = 0, gen2 = 0;
  logic [23:0] bus_addr = '0;
  logic protect, sub_en, write_block, halt;
  logic [15:0] sub_data;
  logic [2:0] arch_limit;
  logic [7:0] exec_limit;
  logic s_sub, s_wb;
  logic [15:0] s_sd;
  int errors = 0, checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  bus_seq_guard #(.ADDR_W(24), .CNT_W(3), .ROM_BASE(24'h200000)) u_dut (
    .clk, .rst_n, .bus_valid, .bus_addr, .bus_write, .bus_word, .gen2,
    .protect, .sub_en, .sub_data, .write_block, .arch_limit, .halt, .exec_limit);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic g);
    @(negedge clk);
    rst_n = 0; gen2 = g; bus_valid = 0;
    @(negedge clk); @(negedge clk);
    rst_n = 1;
  endtask

  task automatic acc(input logic [23:0] a, input logic w, input logic wd);
    bus_addr = a; bus_write = w; bus_word = wd; bus_valid = 1;
    #1;
    s_sub = sub_en; s_sd = sub_data; s_wb = write_block;
    @(negedge clk);
    bus_valid = 0;
  endtask

  task automatic rep(input int n, input logic [23:0] a, input logic w, input logic wd);
    for (int i = 0; i < n; i++) acc(a, w, wd);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    do_reset(0);
    chk("R1 protect", protect, 0);
    chk("R1 halt", halt, 0);
    chk("R1 arch", arch_limit, 0);
    chk("R10 exec gen1", exec_limit, 8'h00);

    rep(3, 24'h200000, 0, 1);
    acc(24'h1C0000, 0, 1);
    chk("R2 R3 unlock read", protect, 1);

    acc(24'h210000, 0, 1);
    chk("R6 sub word", s_sub, 1);
    chk("R6 data", s_sd, 16'h1414);
    acc(24'h218001, 0, 0);
    chk("R6 sub byte", s_sub, 1);
    acc(24'h210000, 1, 1);
    chk("R6 write no sub", s_sub, 0);

    acc(24'h040000, 1, 0);
    chk("R7 locked by protect", arch_limit, 0);

    acc(24'h300000, 0, 1);
    rep(3, 24'h21A000, 1, 1);
    chk("R8 auth write not blocked", s_wb, 0);
    acc(24'h1C0000, 1, 1);
    chk("R3 unlock write clears", protect, 0);

    acc(24'h040000, 1, 0);
    chk("R7 set bit0", arch_limit, 3'b001);
    acc(24'h0C0000, 1, 1);
    chk("R7 set bit2", arch_limit, 3'b101);
    acc(24'h0C0000, 0, 1);
    chk("R7 read clears bit2", arch_limit, 3'b001);
    acc(24'h210000, 0, 1);
    chk("R6 unprotected read", s_sub, 0);

    acc(24'h300000, 0, 1);
    rep(2, 24'h200000, 0, 1);
    acc(24'h100000, 0, 1);
    acc(24'h200000, 0, 1);
    acc(24'h1C0000, 0, 1);
    chk("R5 break resets count", protect, 0);
    acc(24'h300000, 0, 1);

    rep(3, 24'h200001, 0, 0);
    acc(24'h1C0000, 0, 1);
    chk("R2 odd byte ignored", protect, 0);
    rep(3, 24'h200002, 0, 0);
    acc(24'h1C0000, 0, 1);
    chk("R2 even byte counted", protect, 1);

    acc(24'h300000, 0, 1);
    rep(3, 24'h1C0000, 0, 0);
    chk("R4 no halt at 3", halt, 0);
    acc(24'h1C0000, 0, 0);
    chk("R4 halt at 4", halt, 1);
    chk("R4 protect kept", protect, 1);
    acc(24'h300000, 0, 1);
    chk("R4 halt sticky", halt, 1);

    do_reset(1);
    chk("R10 exec gen2", exec_limit, 8'h18);
    chk("R1 protect gen2", protect, 0);
    chk("R1 halt cleared", halt, 0);
    rep(6, 24'h1C0002, 0, 0);
    chk("R3 six bytes short", protect, 0);
    acc(24'h1C0002, 0, 0);
    chk("R3 seventh byte", protect, 1);
    chk("R4 no halt gen2", halt, 0);
    rep(3, 24'h1C0000, 1, 1);
    chk("R3 three words short", protect, 1);
    acc(24'h1C0000, 1, 1);
    chk("R3 fourth word clears", protect, 0);
    acc(24'h080000, 1, 0);
    chk("R7 gen2 ignored", arch_limit, 0);
    rep(2, 24'h212000, 0, 1);
    acc(24'h1C0000, 0, 1);
    chk("R2 gen2 auth to B", protect, 0);
    acc(24'h300000, 0, 1);

    rep(9, 24'h212000, 0, 0);
    acc(24'h1C0000, 0, 0);
    chk("R9 B saturates", protect, 1);

    do_reset(0);
    rep(10, 24'h200000, 0, 1);
    acc(24'h1C0000, 0, 1);
    chk("R9 A saturates", protect, 1);

    acc(24'h20FFFE, 1, 1);
    chk("R8 boot write blocked", s_wb, 1);
    acc(24'h20FFFE, 0, 1);
    chk("R8 boot read", s_wb, 0);
    acc(24'h210000, 1, 1);
    chk("R8 past boot", s_wb, 0);

    begin
      logic [23:0] pts [16];
      logic bt, sc;
      pts = '{24'h000000, 24'h040000, 24'h080000, 24'h0C0000, 24'h100000, 24'h180000,
              24'h200000, 24'h20FFFF, 24'h210000, 24'h211FFF, 24'h212000, 24'h218000,
              24'h219FFF, 24'h21A000, 24'h21FFFF, 24'h220000};
      for (int i = 0; i < 16; i++)
        for (int w = 0; w < 2; w++)
          for (int z = 0; z < 2; z++) begin
            acc(pts[i], w[0], z[0]);
            bt = pts[i] >= 24'h200000 && pts[i] <= 24'h20FFFF;
            sc = (pts[i] >= 24'h210000 && pts[i] <= 24'h211FFF) ||
                 (pts[i] >= 24'h218000 && pts[i] <= 24'h219FFF);
            chk("R8 sweep block", s_wb, w[0] && bt);
            chk("R6 sweep sub", s_sub, !w[0] && sc);
            if (s_sub) chk("R6 sweep data", s_sd, 16'h1414);
            chk("R7 sweep arch", arch_limit, 0);
            chk("R3 sweep protect", protect, 1);
          end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule